// File: doc/BRIEF.md
# Prefetch Sequence Reconstruction Unit

This unit turns a recorded history of region misses into an ordered list of prefetch addresses. It is given a start position and a newest position in a ring-shaped miss order buffer. It walks the buffer twice through a single read port. The first walk lays the base address of each visited region into a fixed array of slots. The slot position advances by each entry's recorded gap plus one.

The second walk repeats the same index progression. For each entry it looks up a pattern table through a read port, keyed by the entry's key. Every learned offset with enough confidence is scattered as a predicted line address into a free slot near its expected position. When both walks are over, the occupied slots leave the block in ascending slot order over a valid/ready stream. A one-cycle completion pulse follows the last address.

Top module: `seq_recon_unit`

## Requirements
- R1: After synchronous reset, `busy`, `pf_valid` and `done` are low.
- R2: A `start` pulse accepted while idle empties every slot. The first visited buffer entry then places its region base (region number shifted left by 12) in slot 0. Each later visited entry places its base at the previous index plus that entry's delta field plus one. A buffer entry word is region number [39:20], key [19:4], delta [3:0].
- R3: The first walk visits entries from `start_pos` forward, wrapping from the last buffer position to 0. It stops after the entry at `newest_pos`, or as soon as the computed index reaches the slot count. An entry whose index would reach the slot count places nothing.
- R4: The second walk restarts at index 0 and advances exactly as the first. Each visited entry with an in-range index is looked up with its key. `pt_touch` is high for exactly one cycle for each such entry that hits.
- R5: A pattern row holds 8 slots of 12 bits, slot j at bits [12j+11:12j]. Each slot is confidence [11:10], line offset [9:4], sequence delta [3:0]. Only slots whose confidence is 2 or 3 produce a prediction.
- R6: A predicted address equals the entry's region base plus the line offset times 64.
- R7: A prediction aims at the entry's index plus the slot's sequence delta. If that slot is taken, the unit tries +1, then +2, then -1, then -2, and skips any position outside the array. The prediction is dropped when all of them are taken. An occupied slot is never overwritten.
- R8: Occupied slots are emitted in ascending index order, one address per accepted transfer. While `pf_ready` is low, `pf_valid` stays high and `pf_addr` holds.
- R9: `done` is high for exactly one cycle after the last address is accepted. `busy` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reconstruction (honoured when idle) |
| start_pos | input | 4 | Buffer position of the first entry to visit |
| newest_pos | input | 4 | Buffer position of the newest entry |
| busy | output | 1 | Reconstruction in progress |
| mob_rd_ptr | output | 4 | Miss order buffer read address |
| mob_rd_data | input | 40 | Entry at `mob_rd_ptr`, same cycle |
| pt_lookup | output | 1 | Pattern table lookup active |
| pt_key | output | 16 | Lookup key |
| pt_hit | input | 1 | Key present in the pattern table, same cycle |
| pt_row | input | 96 | Pattern row for `pt_key` |
| pt_touch | output | 1 | Refresh recency of the hit row |
| pf_valid | output | 1 | Prefetch address available |
| pf_ready | input | 1 | Consumer accepts the address |
| pf_addr | output | 32 | Prefetch byte address |
| done | output | 1 | Completion pulse |

## Verification
On every cycle, the assertions check several local invariants. A write never lands in an occupied slot, and a chosen slot lies within two of its target. The slot array is empty after a start. The output holds under backpressure, and the touch and completion pulses last one cycle. Some behaviours only the directed scenarios can show: the exact slots reached through accumulated deltas and ring wrap, the early stop at the slot limit, and the confidence filter. They also cover the ordered fallback, including the dropped prediction, and the full emitted address list compared against an independent model of the requirements.

// File: rtl/seq_recon_pkg.sv
package seq_recon_pkg;

    localparam int ADDR_W       = 32;
    localparam int REGION_SHIFT = 12;
    localparam int LINE_SHIFT   = 6;
    localparam int OFF_W        = REGION_SHIFT - LINE_SHIFT;
    localparam int REG_W        = ADDR_W - REGION_SHIFT;
    localparam int KEY_W        = 16;
    localparam int MDELTA_W     = 4;
    localparam int SEQ_W        = 4;
    localparam int PAT_SLOTS    = 8;

    typedef struct packed {
        logic [REG_W-1:0]    region;
        logic [KEY_W-1:0]    key;
        logic [MDELTA_W-1:0] delta;
    } mob_entry_t;

    typedef struct packed {
        logic [1:0]       conf;
        logic [OFF_W-1:0] offset;
        logic [SEQ_W-1:0] seq;
    } pat_slot_t;

    localparam int MOB_ENT_W = $bits(mob_entry_t);
    localparam int PSLOT_W   = $bits(pat_slot_t);
    localparam int PROW_W    = PSLOT_W * PAT_SLOTS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK1,
        ST_STEP2,
        ST_SCAT,
        ST_EMIT,
        ST_DONE
    } recon_state_t;

    function automatic logic [ADDR_W-1:0] region_base(input logic [REG_W-1:0] r);
        return {r, {REGION_SHIFT{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] line_addr(input logic [REG_W-1:0] r,
                                                    input logic [OFF_W-1:0] o);
        return {r, o, {LINE_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/recon_place_pick.sv
module recon_place_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 7,
    localparam int SI_W = $clog2(N)
) (
    input  logic [N-1:0]     occ,
    input  logic [IDX_W-1:0] target,
    output logic             found,
    output logic [SI_W-1:0]  pick
);
    localparam int NCAND = 5;

    logic [IDX_W-1:0] cand   [NCAND];
    logic             in_rng [NCAND];
    logic             usable [NCAND];

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        if (k < 3) begin : g_up
            assign cand[k]   = target + IDX_W'(k);
            assign in_rng[k] = cand[k] < IDX_W'(N);
        end else begin : g_down
            assign cand[k]   = target - IDX_W'(k - 2);
            assign in_rng[k] = (target >= IDX_W'(k - 2)) && (cand[k] < IDX_W'(N));
        end
        assign usable[k] = in_rng[k] && !occ[cand[k][SI_W-1:0]];
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = NCAND - 1; k >= 0; k--) begin
            if (usable[k]) begin
                found = 1'b1;
                pick  = cand[k][SI_W-1:0];
            end
        end
    end

endmodule

// File: rtl/recon_slot_store.sv
module recon_slot_store
    import seq_recon_pkg::*;
#(
    parameter int N     = 16,
    localparam int SI_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SI_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SI_W-1:0]   rd_idx,
    output logic [N-1:0]      occ,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] slot_addr [N];

    for (genvar s = 0; s < N; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                occ[s] <= 1'b0;
            end else if (wr_en && wr_idx == SI_W'(s)) begin
                occ[s] <= 1'b1;
            end
            if (wr_en && wr_idx == SI_W'(s)) begin
                slot_addr[s] <= wr_addr;
            end
        end
    end

    assign rd_addr = slot_addr[rd_idx];

    assert_free_slot_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !occ[wr_idx]);

    assert_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        clear |=> (occ == '0));

    assert_written_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clear) |=> occ[$past(wr_idx)] && (slot_addr[$past(wr_idx)] == $past(wr_addr)));

endmodule

// File: rtl/seq_recon_unit.sv
module seq_recon_unit
    import seq_recon_pkg::*;
#(
    parameter int N_SLOTS   = 16,
    parameter int MOB_DEPTH = 16,
    localparam int MP_W     = $clog2(MOB_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [MP_W-1:0]      start_pos,
    input  logic [MP_W-1:0]      newest_pos,
    output logic                 busy,
    output logic [MP_W-1:0]      mob_rd_ptr,
    input  logic [MOB_ENT_W-1:0] mob_rd_data,
    output logic                 pt_lookup,
    output logic [KEY_W-1:0]     pt_key,
    input  logic                 pt_hit,
    input  logic [PROW_W-1:0]    pt_row,
    output logic                 pt_touch,
    output logic                 pf_valid,
    input  logic                 pf_ready,
    output logic [ADDR_W-1:0]    pf_addr,
    output logic                 done
);
    localparam int SI_W  = $clog2(N_SLOTS);
    localparam int IDX_W = $clog2(N_SLOTS + (1 << MDELTA_W) + (1 << SEQ_W)) + 1;
    localparam int J_W   = $clog2(PAT_SLOTS);

    recon_state_t     state;
    logic [MP_W-1:0]  ptr, first_ptr, last_ptr, ptr_nxt;
    logic [IDX_W-1:0] idx, next_idx, target;
    logic             first;
    logic [J_W-1:0]   j;
    logic [SI_W-1:0]  eptr;

    mob_entry_t ment;
    pat_slot_t  cur_slot;
    logic [N_SLOTS-1:0] occ;
    logic               found, want, scat_last, idx_over;
    logic [SI_W-1:0]    pick;
    logic               st_clear, st_wr;
    logic [SI_W-1:0]    st_idx;
    logic [ADDR_W-1:0]  st_addr, rd_addr;

    assign ment      = mob_entry_t'(mob_rd_data);
    assign cur_slot  = pat_slot_t'(pt_row[j*PSLOT_W +: PSLOT_W]);
    assign ptr_nxt   = (ptr == MP_W'(MOB_DEPTH - 1)) ? '0 : ptr + 1'b1;
    assign next_idx  = first ? '0 : idx + IDX_W'(ment.delta) + IDX_W'(1);
    assign idx_over  = next_idx >= IDX_W'(N_SLOTS);
    assign target    = idx + IDX_W'(cur_slot.seq);
    assign want      = (state == ST_SCAT) && pt_hit && (cur_slot.conf >= 2'd2);
    assign scat_last = !pt_hit || (j == J_W'(PAT_SLOTS - 1));

    recon_place_pick #(.N(N_SLOTS), .IDX_W(IDX_W)) u_pick (
        .occ    (occ),
        .target (target),
        .found  (found),
        .pick   (pick)
    );

    assign st_clear = (state == ST_IDLE) && start;
    assign st_wr    = ((state == ST_WALK1) && !idx_over) || (want && found);
    assign st_idx   = (state == ST_WALK1) ? next_idx[SI_W-1:0] : pick;
    assign st_addr  = (state == ST_WALK1) ? region_base(ment.region)
                                          : line_addr(ment.region, cur_slot.offset);

    recon_slot_store #(.N(N_SLOTS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (st_clear),
        .wr_en   (st_wr),
        .wr_idx  (st_idx),
        .wr_addr (st_addr),
        .rd_idx  (eptr),
        .occ     (occ),
        .rd_addr (rd_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ptr       <= '0;
            first_ptr <= '0;
            last_ptr  <= '0;
            idx       <= '0;
            first     <= 1'b1;
            j         <= '0;
            eptr      <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ptr       <= start_pos;
                    first_ptr <= start_pos;
                    last_ptr  <= newest_pos;
                    first     <= 1'b1;
                    idx       <= '0;
                    state     <= ST_WALK1;
                end
                ST_WALK1: begin
                    if (idx_over || ptr == last_ptr) begin
                        ptr   <= first_ptr;
                        first <= 1'b1;
                        state <= ST_STEP2;
                    end else begin
                        idx   <= next_idx;
                        first <= 1'b0;
                        ptr   <= ptr_nxt;
                    end
                end
                ST_STEP2: begin
                    if (idx_over) begin
                        eptr  <= '0;
                        state <= ST_EMIT;
                    end else begin
                        idx   <= next_idx;
                        first <= 1'b0;
                        j     <= '0;
                        state <= ST_SCAT;
                    end
                end
                ST_SCAT: begin
                    if (scat_last) begin
                        if (ptr == last_ptr) begin
                            eptr  <= '0;
                            state <= ST_EMIT;
                        end else begin
                            ptr   <= ptr_nxt;
                            state <= ST_STEP2;
                        end
                    end else begin
                        j <= j + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (!occ[eptr] || pf_ready) begin
                        if (eptr == SI_W'(N_SLOTS - 1)) state <= ST_DONE;
                        else eptr <= eptr + 1'b1;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign mob_rd_ptr = ptr;
    assign pt_key     = ment.key;
    assign pt_lookup  = (state == ST_SCAT);
    assign pt_touch   = (state == ST_SCAT) && (j == '0) && pt_hit;
    assign pf_valid   = (state == ST_EMIT) && occ[eptr];
    assign pf_addr    = rd_addr;
    assign done       = (state == ST_DONE);

    assert_touch_once_R4: assert property (@(posedge clk) disable iff (rst)
        pt_touch |=> !pt_touch);

    assert_near_target_R7: assert property (@(posedge clk) disable iff (rst)
        (want && found) |-> ((IDX_W'(pick) <= target + IDX_W'(2)) && (IDX_W'(pick) + IDX_W'(2) >= target)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

// File: tb/sim_seq_recon_unit.sv
module sim_seq_recon_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  start_pos, newest_pos;
    logic        busy;
    logic [3:0]  mob_rd_ptr;
    logic [39:0] mob_rd_data;
    logic        pt_lookup;
    logic [15:0] pt_key;
    logic        pt_hit;
    logic [95:0] pt_row;
    logic        pt_touch;
    logic        pf_valid, pf_ready, done;
    logic [31:0] pf_addr;

    always #5 clk = ~clk;

    seq_recon_unit u0 (
        .clk(clk), .rst(rst), .start(start), .start_pos(start_pos), .newest_pos(newest_pos),
        .busy(busy), .mob_rd_ptr(mob_rd_ptr), .mob_rd_data(mob_rd_data),
        .pt_lookup(pt_lookup), .pt_key(pt_key), .pt_hit(pt_hit), .pt_row(pt_row),
        .pt_touch(pt_touch), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_addr(pf_addr), .done(done)
    );

    logic [19:0] m_reg [16];
    logic [15:0] m_key [16];
    logic [3:0]  m_dl  [16];
    logic [15:0] p_key [4];
    logic        p_val [4];
    logic [95:0] p_row [4];

    assign mob_rd_data = {m_reg[mob_rd_ptr], m_key[mob_rd_ptr], m_dl[mob_rd_ptr]};

    always_comb begin
        pt_hit = 1'b0;
        pt_row = '0;
        for (int i = 0; i < 4; i++) begin
            if (p_val[i] && p_key[i] == pt_key) begin
                pt_hit = 1'b1;
                pt_row = p_row[i];
            end
        end
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mkslot(input int conf, input int off, input int seq);
        return {conf[1:0], off[5:0], seq[3:0]};
    endfunction

    // independent model of the requirements
    logic        ev [16];
    logic [31:0] ea [16];
    int          exp_touch;

    task automatic model_place(input int t, input logic [31:0] a);
        int cands [5];
        bit placed;
        cands = '{t, t + 1, t + 2, t - 1, t - 2};
        placed = 0;
        for (int c = 0; c < 5; c++) begin
            if (!placed && cands[c] >= 0 && cands[c] < 16 && !ev[cands[c]]) begin
                ev[cands[c]] = 1'b1;
                ea[cands[c]] = a;
                placed = 1;
            end
        end
    endtask

    task automatic model(input int sp, input int np);
        int  p, idx;
        bit  first;
        bit  hit;
        logic [95:0] row;
        logic [11:0] s;
        for (int i = 0; i < 16; i++) begin ev[i] = 1'b0; ea[i] = '0; end
        exp_touch = 0;
        p = sp; idx = 0; first = 1;
        forever begin
            if (!first) idx = idx + int'(m_dl[p]) + 1;
            if (idx >= 16) break;
            ev[idx] = 1'b1;
            ea[idx] = {m_reg[p], 12'h000};
            first = 0;
            if (p == np) break;
            p = (p + 1) % 16;
        end
        p = sp; idx = 0; first = 1;
        forever begin
            if (!first) idx = idx + int'(m_dl[p]) + 1;
            if (idx >= 16) break;
            first = 0;
            hit = 0; row = '0;
            for (int i = 0; i < 4; i++)
                if (p_val[i] && p_key[i] == m_key[p]) begin hit = 1; row = p_row[i]; end
            if (hit) begin
                exp_touch++;
                for (int jj = 0; jj < 8; jj++) begin
                    s = row[jj*12 +: 12];
                    if (s[11:10] >= 2'd2)
                        model_place(idx + int'(s[3:0]), {m_reg[p], 12'h000} + 32'(s[9:4]) * 64);
                end
            end
            if (p == np) break;
            p = (p + 1) % 16;
        end
    endtask

    logic [31:0] got [32];
    int          ng;

    task automatic run(input int sp, input int np, input int rmode, input string tag);
        int cyc, touches, ne;
        bit fin, hold_pending;
        logic [31:0] hold_addr;
        model(sp, np);
        ng = 0; touches = 0; cyc = 0; fin = 0; hold_pending = 0; hold_addr = '0;
        @(negedge clk);
        start = 1'b1; start_pos = 4'(sp); newest_pos = 4'(np);
        @(negedge clk);
        start = 1'b0;
        while (!fin) begin
            pf_ready = (rmode == 0) ? 1'b1 : (cyc % 3 == 2);
            #1;
            if (hold_pending) begin
                check(pf_valid && pf_addr == hold_addr, {"R8 hold ", tag}, pf_addr, hold_addr);
            end
            hold_pending = pf_valid && !pf_ready;
            hold_addr = pf_addr;
            if (pt_touch) touches++;
            if (pf_valid && pf_ready && ng < 32) begin got[ng] = pf_addr; ng++; end
            if (done) fin = 1;
            cyc++;
            if (cyc > 5000) begin
                check(0, {"watchdog ", tag}, 32'(cyc), 32'd5000);
                fin = 1;
            end
            @(negedge clk);
        end
        #1;
        check(!done && !busy, {"R9 pulse end ", tag}, {30'd0, done, busy}, 32'd0);
        ne = 0;
        for (int i = 0; i < 16; i++) begin
            if (ev[i]) begin
                if (ne < ng) check(got[ne] == ea[i], {"R8 order/address ", tag}, got[ne], ea[i]);
                ne++;
            end
        end
        check(ng == ne, {"R8 count ", tag}, 32'(ng), 32'(ne));
        check(touches == exp_touch, {"R4 touches ", tag}, 32'(touches), 32'(exp_touch));
    endtask

    task automatic clear_tables();
        for (int i = 0; i < 16; i++) begin
            m_reg[i] = 20'(32'h0F000 + i); m_key[i] = 16'(32'hF000 + i); m_dl[i] = 4'd0;
        end
        for (int i = 0; i < 4; i++) begin p_key[i] = '0; p_val[i] = 1'b0; p_row[i] = '0; end
    endtask

    task automatic scn_reset();
        #1;
        check(!busy && !pf_valid && !done, "R1 reset state", {29'd0, busy, pf_valid, done}, 32'd0);
    endtask

    task automatic scn_bases();
        clear_tables();
        m_reg[0] = 20'h00100; m_dl[0] = 4'd5;
        m_reg[1] = 20'h00200; m_dl[1] = 4'd0;
        m_reg[2] = 20'h00300; m_dl[2] = 4'd2;
        m_reg[3] = 20'h00400; m_dl[3] = 4'd1;
        run(0, 3, 0, "bases");
        check(ng == 4, "R2 base count", 32'(ng), 32'd4);
        check(got[0] == 32'h00100000, "R2 first base in slot 0", got[0], 32'h00100000);
        check(got[3] == 32'h00400000, "R2 last base", got[3], 32'h00400000);
    endtask

    task automatic scn_patterns();
        bit seen_low;
        clear_tables();
        m_reg[0] = 20'h00100; m_key[0] = 16'hAAAA; m_dl[0] = 4'd3;
        m_reg[1] = 20'h00200; m_dl[1] = 4'd0;
        m_reg[2] = 20'h00300; m_key[2] = 16'hBBBB; m_dl[2] = 4'd2;
        m_reg[3] = 20'h00400; m_dl[3] = 4'd1;
        p_val[0] = 1'b1; p_key[0] = 16'hAAAA;
        p_row[0] = {60'd0, mkslot(2, 9, 5), mkslot(1, 7, 3), mkslot(3, 5, 0)};
        p_val[1] = 1'b1; p_key[1] = 16'hBBBB;
        p_row[1] = {84'd0, mkslot(3, 1, 0)};
        run(0, 3, 0, "patterns");
        check(ng == 7, "R7 prediction count", 32'(ng), 32'd7);
        check(got[2] == 32'h00100140, "R7 +2 fallback / R6 address", got[2], 32'h00100140);
        check(got[3] == 32'h00300040, "R7 -1 fallback", got[3], 32'h00300040);
        check(got[5] == 32'h00100240, "R6 direct target", got[5], 32'h00100240);
        seen_low = 0;
        for (int i = 0; i < ng; i++) if (got[i] == 32'h001001C0) seen_low = 1;
        check(!seen_low, "R5 low confidence ignored", {31'd0, seen_low}, 32'd0);
    endtask

    task automatic scn_drop();
        clear_tables();
        m_reg[0] = 20'h00500; m_key[0] = 16'hC0C0;
        m_reg[1] = 20'h00600;
        m_reg[2] = 20'h00700;
        p_val[2] = 1'b1; p_key[2] = 16'hC0C0;
        p_row[2] = {60'd0, mkslot(3, 4, 1), mkslot(2, 3, 0), mkslot(3, 2, 0)};
        run(0, 2, 0, "drop");
        check(ng == 4, "R7 crowded predictions dropped", 32'(ng), 32'd4);
        check(got[3] == 32'h00500100, "R7 surviving prediction", got[3], 32'h00500100);
    endtask

    task automatic scn_wrap();
        clear_tables();
        m_reg[14] = 20'h0A000; m_dl[14] = 4'd9;
        m_reg[15] = 20'h0B000; m_dl[15] = 4'd7;
        m_reg[0]  = 20'h0C000; m_dl[0]  = 4'd6;
        m_reg[1]  = 20'h0D000; m_dl[1]  = 4'd0;
        run(14, 5, 1, "wrap");
        check(ng == 3, "R3 stop at slot limit", 32'(ng), 32'd3);
        check(got[1] == 32'h0B000000, "R3 wrap order", got[1], 32'h0B000000);
        check(got[2] == 32'h0C000000, "R3 last slot", got[2], 32'h0C000000);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; start_pos = '0; newest_pos = '0; pf_ready = 1'b0;
        clear_tables();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        scn_reset();
        scn_bases();
        scn_patterns();
        scn_drop();
        scn_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule